// File: doc/BRIEF.md
# Tester Parallel Bridge with Loopback

This block joins a wide 40 MHz frame-rate datapath to a narrow bundle of tester pins that runs at four times the frame rate. On the outbound side, each wide frame word is cut into four lane-wide slices, and the slices are driven on four consecutive fast-clock cycles, lowest slice first. On the inbound side, four consecutive fast-clock samples of the receive lanes are put back together into one wide word. That word is handed to the frame domain once the whole frame has been captured.

The top output pin is not a data lane. It carries a frame-clock-registered OR of a set of lock, ready and data-valid flags, so one line gives a quick sign that the link is healthy. A loopback mode ties every input pin directly to the output pin with the same index, with no flip-flop in the path. This lets the pin harness be checked without the datapath. Loopback is on when either a software control bit is high or an active-low switch input is low.

Top module: `tester_par_bridge`

## Requirements
- R1: While rst_n is low and loopback is off, every bit of pin_out reads 0 and rx_word reads 0.
- R2: tx_word is sampled at every rising edge of clk_frame. The sampled value is then serialised during the following frame.
- R3: Slice k of the sampled transmit word is bits [k*30 +: 30]. It appears on pin_out[29:0] after the (k+1)-th rising edge of clk_fast that follows the clk_frame edge which sampled the word, and it stays there for one fast cycle. The slices go out in the order 0, 1, 2, 3.
- R4: The value on pin_in[28:0] at the (k+1)-th rising edge of clk_fast after a clk_frame edge becomes bits [k*29 +: 29] of the received word.
- R5: A received word is presented on rx_word at the first clk_frame rising edge after its slice 3 was captured. It then holds for one frame.
- R6: Outside loopback, pin_out[30] equals the OR of all lock_flags bits as sampled at the previous clk_frame rising edge.
- R7: When loop_sw is 1, pin_out equals pin_in on all 31 bits, combinationally.
- R8: When loop_dip_n is 0, loopback is also on, whatever the value of loop_sw. Only when loop_sw is 0 and loop_dip_n is 1 does pin_out carry the serialised data and the status bit.
- R9: The slice phase counter is reset by rst_n. The first frame after reset release therefore drives all-zero slices, and the word sampled at the next clk_frame edge starts at slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_frame | input | 1 | Frame-rate clock (40 MHz nominal) |
| clk_fast | input | 1 | Pin-rate clock, 4x clk_frame, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset, released just after a clk_frame edge |
| tx_word | input | 120 | Wide word to serialise, frame domain |
| rx_word | output | 116 | Reassembled received word, frame domain |
| lock_flags | input | 4 | Lock, ready and data-valid flags ORed onto the status pin |
| loop_sw | input | 1 | Software loopback request, active high |
| loop_dip_n | input | 1 | Switch loopback request, active low |
| pin_in | input | 31 | Tester input pins; the low 29 are receive lanes |
| pin_out | output | 31 | Tester output pins; the low 30 are transmit lanes, bit 30 is status |

## Verification
The assertions assume four things:
- clk_fast runs at exactly four times clk_frame, and every clk_frame rising edge falls on a clk_fast rising edge.
- rst_n is released after a clk_frame edge and before the next clk_fast edge, so the phase counter restarts in step with the frames.
- The data, flag and pin inputs change only between clock edges.
- The software loopback bit is taken as a plain level.

The bench makes both clocks from one timebase with aligned rising edges. It releases reset two time units after a frame edge, and it changes every input at the midpoint of a fast cycle.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  // Source selected for the output pins
  typedef enum logic {
    SRC_CORE = 1'b0,
    SRC_LOOP = 1'b1
  } pin_src_e;

  localparam int unsigned TPB_SLICES_DEF = 4;

endpackage

// File: rtl/tpb_slice_phase.sv
module tpb_slice_phase #(
  parameter  int unsigned SLICES = 4,
  localparam int unsigned PH_W   = $clog2(SLICES)
) (
  input  logic            clk_fast,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;
  logic            ph_en;

  assign ph_en = 1'b1;

  always_comb begin
    if (ph_q == PH_W'(SLICES - 1)) ph_nxt = '0;
    else                           ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_nxt;
  end

  assign ph = ph_q;

  // Last slice is followed by slice 0, so frames stay aligned
  assert_phase_wrap_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ph_q == PH_W'(SLICES - 1)) |=> (ph_q == '0));

endmodule

// File: rtl/tpb_tx_slicer.sv
module tpb_tx_slicer #(
  parameter  int unsigned LANES  = 30,
  parameter  int unsigned SLICES = 4,
  localparam int unsigned PH_W   = $clog2(SLICES),
  localparam int unsigned W      = LANES * SLICES
) (
  input  logic             clk_frame,
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph,
  input  logic [W-1:0]     word,
  output logic [LANES-1:0] lanes
);

  logic [W-1:0]     hold_q;
  logic             hold_en;
  logic [LANES-1:0] lane_q;
  logic [LANES-1:0] lane_nxt;
  logic             lane_en;

  assign hold_en = 1'b1;
  assign lane_en = 1'b1;

  // Frame domain: sample the whole word once per frame
  always_ff @(posedge clk_frame or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= word;
  end

  // Fast domain: pick the slice named by the phase
  always_comb begin
    lane_nxt = hold_q[int'(ph) * LANES +: LANES];
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)       lane_q <= '0;
    else if (lane_en) lane_q <= lane_nxt;
  end

  assign lanes = lane_q;

  // Phase 0 drives the least significant slice of the held word
  assert_first_slice_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ph == '0) |=> (lane_q == $past(hold_q[LANES-1:0])));

endmodule

// File: rtl/tpb_rx_gather.sv
module tpb_rx_gather #(
  parameter  int unsigned LANES  = 29,
  parameter  int unsigned SLICES = 4,
  localparam int unsigned PH_W   = $clog2(SLICES),
  localparam int unsigned W      = LANES * SLICES
) (
  input  logic             clk_frame,
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph,
  input  logic [LANES-1:0] lanes,
  output logic [W-1:0]     word
);

  logic [SLICES-2:0][LANES-1:0] acc_q;
  logic [SLICES-2:0]            cap_en;
  logic [W-1:0]                 full_q;
  logic [W-1:0]                 full_nxt;
  logic                         full_en;
  logic [W-1:0]                 word_q;
  logic                         word_en;

  // One capture register per early slice
  for (genvar k = 0; k < SLICES - 1; k++) begin : g_cap
    assign cap_en[k] = (ph == PH_W'(k));
    always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)         acc_q[k] <= '0;
      else if (cap_en[k]) acc_q[k] <= lanes;
    end
  end

  // Last slice completes the frame
  assign full_en  = (ph == PH_W'(SLICES - 1));
  always_comb begin
    full_nxt = {lanes, acc_q};
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)       full_q <= '0;
    else if (full_en) full_q <= full_nxt;
  end

  // Hand-over to the frame domain
  assign word_en = 1'b1;
  always_ff @(posedge clk_frame or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= full_q;
  end

  assign word = word_q;

  // Lane value at the last phase lands in the top slice of the frame
  assert_top_slice_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ph == PH_W'(SLICES - 1)) |=> (full_q[W-1 -: LANES] == $past(lanes)));

endmodule

// File: rtl/tester_par_bridge.sv
module tester_par_bridge
  import tpb_pkg::*;
#(
  parameter  int unsigned RX_LANES = 29,
  parameter  int unsigned TX_LANES = 30,
  parameter  int unsigned SLICES   = TPB_SLICES_DEF,
  parameter  int unsigned NFLAGS   = 4,
  localparam int unsigned PINS     = TX_LANES + 1,
  localparam int unsigned RX_W     = RX_LANES * SLICES,
  localparam int unsigned TX_W     = TX_LANES * SLICES,
  localparam int unsigned PH_W     = $clog2(SLICES)
) (
  input  logic              clk_frame,
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic [TX_W-1:0]   tx_word,
  output logic [RX_W-1:0]   rx_word,
  input  logic [NFLAGS-1:0] lock_flags,
  input  logic              loop_sw,
  input  logic              loop_dip_n,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out
);

  logic [PH_W-1:0]     ph;
  logic [TX_LANES-1:0] tx_lanes;
  logic                status_q;
  logic                status_nxt;
  logic                status_en;
  logic [PINS-1:0]     core_out;
  pin_src_e            pin_src;

  tpb_slice_phase #(.SLICES(SLICES)) u_phase (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .ph       (ph)
  );

  tpb_tx_slicer #(.LANES(TX_LANES), .SLICES(SLICES)) u_tx (
    .clk_frame (clk_frame),
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .ph        (ph),
    .word      (tx_word),
    .lanes     (tx_lanes)
  );

  tpb_rx_gather #(.LANES(RX_LANES), .SLICES(SLICES)) u_rx (
    .clk_frame (clk_frame),
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .ph        (ph),
    .lanes     (pin_in[RX_LANES-1:0]),
    .word      (rx_word)
  );

  // Health flag, frame domain
  assign status_en = 1'b1;
  always_comb begin
    status_nxt = |lock_flags;
  end

  always_ff @(posedge clk_frame or negedge rst_n) begin
    if (!rst_n)         status_q <= 1'b0;
    else if (status_en) status_q <= status_nxt;
  end

  // Pin source: either request turns on the wire-through path
  always_comb begin
    pin_src  = (loop_sw || !loop_dip_n) ? SRC_LOOP : SRC_CORE;
    core_out = {status_q, tx_lanes};
    pin_out  = (pin_src == SRC_LOOP) ? pin_in : core_out;
  end

  // Status pin follows the flags of the previous frame edge
  assert_status_or_R6: assert property (@(posedge clk_frame) disable iff (!rst_n)
    (!loop_sw && loop_dip_n && |lock_flags) |=> (status_q && (pin_out[PINS-1] || !loop_dip_n || loop_sw)));

  assert_status_idle_R6: assert property (@(posedge clk_frame) disable iff (!rst_n)
    (lock_flags == '0) |=> !status_q);

  // Software request alone is enough for a full pin pass-through
  assert_loop_sw_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    loop_sw |-> (pin_out == pin_in));

  // Switch request alone is enough as well
  assert_loop_dip_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !loop_dip_n |-> (pin_out == pin_in));

endmodule

// File: tb/sim_tester_par_bridge.sv
module sim_tester_par_bridge;

  localparam int RXL   = 29;
  localparam int TXL   = 30;
  localparam int NS    = 4;
  localparam int NF    = 4;
  localparam int PINS  = TXL + 1;
  localparam int RXW   = RXL * NS;
  localparam int TXW   = TXL * NS;
  localparam int EDGES = 4 * 40;

  logic            clk_frame;
  logic            clk_fast;
  logic            rst_n;
  logic [TXW-1:0]  tx_word;
  logic [RXW-1:0]  rx_word;
  logic [NF-1:0]   lock_flags;
  logic            loop_sw;
  logic            loop_dip_n;
  logic [PINS-1:0] pin_in;
  logic [PINS-1:0] pin_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tester_par_bridge u0 (
    .clk_frame  (clk_frame),
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .tx_word    (tx_word),
    .rx_word    (rx_word),
    .lock_flags (lock_flags),
    .loop_sw    (loop_sw),
    .loop_dip_n (loop_dip_n),
    .pin_in     (pin_in),
    .pin_out    (pin_out)
  );

  // 125 MHz pin clock, frame clock at a quarter with aligned rising edges
  initial begin
    clk_fast = 1'b0;
    forever #4 clk_fast = ~clk_fast;
  end

  initial begin
    clk_frame = 1'b0;
    #4;
    forever begin
      clk_frame = 1'b1;
      #16;
      clk_frame = 1'b0;
      #16;
    end
  end

  function automatic logic [TXW-1:0] gen_tx(int m);
    logic [TXW-1:0] w;
    case (m % 4)
      0: w = '1;
      1: w = ~({{(TXW-1){1'b0}}, 1'b1} << (m % TXW));
      2: w = '0;
      default: for (int i = 0; i < TXW; i++) w[i] = (((i * 3) + m) % 7) < 3;
    endcase
    return w;
  endfunction

  function automatic logic [RXW-1:0] gen_rx(int q);
    logic [RXW-1:0] w;
    case (q % 3)
      0: for (int i = 0; i < RXW; i++) w[i] = (((i * 5) + (q * 3)) % 11) < 5;
      1: w = {{(RXW-1){1'b0}}, 1'b1} << (q % RXW);
      default: w = '1;
    endcase
    return w;
  endfunction

  function automatic logic [TXL-1:0] tx_slc(logic [TXW-1:0] w, int k);
    return w[k*TXL +: TXL];
  endfunction

  function automatic logic [RXL-1:0] rx_slc(logic [RXW-1:0] w, int k);
    return w[k*RXL +: RXL];
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NF-1:0] last_flags;
    rst_n      = 1'b0;
    tx_word    = '1;
    lock_flags = '1;
    loop_sw    = 1'b0;
    loop_dip_n = 1'b1;
    pin_in     = '1;
    repeat (3) @(posedge clk_frame);
    #4;
    // R1: reset holds the core path quiet despite busy inputs
    chk("R1 pins", 128'(pin_out), 128'(0));
    chk("R1 rx_word", 128'(rx_word), 128'(0));

    @(posedge clk_frame);
    #2;
    rst_n      = 1'b1;
    tx_word    = gen_tx(0);
    lock_flags = '0;
    last_flags = '0;
    pin_in     = {2'b11, rx_slc(gen_rx(0), 0)};

    for (int n = 0; n < EDGES; n++) begin
      @(posedge clk_fast);
      #4;
      if (n < 4) begin
        // R9: first frame after release sends the reset-time zeros
        chk("R9 first frame", 128'(pin_out[TXL-1:0]), 128'(0));
      end else begin
        // R2 R3: slice n%4 of the word sampled one frame earlier
        chk("R3 tx slice", 128'(pin_out[TXL-1:0]), 128'(tx_slc(gen_tx(n / 4 - 1), n % 4)));
      end
      if (n % 4 == 3) begin
        if (n < 7) chk("R5 rx initial", 128'(rx_word), 128'(0));
        else       chk("R4 R5 rx word", 128'(rx_word), 128'(gen_rx((n - 3) / 4 - 1)));
        chk("R6 status", 128'(pin_out[PINS-1]), 128'(|last_flags));
        tx_word    = gen_tx(n / 4 + 1);
        lock_flags = NF'((n / 4 + 1) % 16);
        last_flags = lock_flags;
      end
      pin_in = {2'b11, rx_slc(gen_rx((n + 1) / 4), (n + 1) % 4)};
    end

    // R7: software loopback, whole pin set
    loop_sw = 1'b1;
    for (int p = 0; p < 8; p++) begin
      pin_in = PINS'(31'h5A5A_1234 * (p + 1)) ^ PINS'(p << 29);
      #3;
      chk("R7 loop_sw", 128'(pin_out), 128'(pin_in));
    end
    // R8: switch loopback on its own
    loop_sw    = 1'b0;
    loop_dip_n = 1'b0;
    for (int p = 0; p < 8; p++) begin
      pin_in = ~(PINS'(31'h0F0F_3C3C) << p);
      #3;
      chk("R8 loop_dip", 128'(pin_out), 128'(pin_in));
    end
    // R8: both requests off gives the core path back
    loop_dip_n = 1'b1;
    tx_word    = '0;
    lock_flags = '0;
    pin_in     = '1;
    repeat (3) @(posedge clk_frame);
    #4;
    chk("R8 core path", 128'(pin_out), 128'(0));
    lock_flags = 4'b0100;
    repeat (2) @(posedge clk_frame);
    #4;
    chk("R6 R8 status back", 128'(pin_out), 128'({1'b1, {TXL{1'b0}}}));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule